// File: doc/BRIEF.md
# Guarded Scratchpad RAM

This block is a small on-chip scratchpad memory of 256 bytes. It answers memory cycles in a fixed address window, which defaults to 0x1000 to 0x10FF. The lowest 64 bytes of the window form a guarded zone. Software can lock that zone, open it, or open it for one single write. Bytes above the zone can always be written.

The protection state changes when a data byte is written to a control I/O port. A fixed "open" code removes the lock until the next control write. A fixed "one-shot" code allows one write into the guarded zone, after which the lock comes back by itself. Any other value locks the zone.

An I/O status port reports the lock state in one bit. Reads from the RAM are never affected by protection. Memory reads and status reads both return their data in a register, one cycle after the request.

Top module: `scratch_guard_ram`

## Requirements
- R1: Only memory addresses 0x1000 to 0x10FF select the RAM. An access outside that window writes nothing, and a read outside it leaves `mem_rdata` unchanged.
- R2: A memory read inside the window presents the stored byte on `mem_rdata` one cycle after the request. `mem_rdata` holds its value when no read hits the window, and it is 0x00 after reset.
- R3: After reset the guarded zone 0x1000 to 0x103F is locked.
- R4: While the zone is locked, a write into 0x1000 to 0x103F is dropped silently and the stored byte stays unchanged.
- R5: Writes to 0x1040 to 0x10FF are always stored, whatever the protection state.
- R6: Writing 0x66 to I/O port 0xEA opens the guarded zone until the next control write.
- R7: Writing 0x55 to port 0xEA allows exactly one write into the guarded zone. The cycle after that write, the zone is locked again.
- R8: In one-shot mode, writes to 0x1040 to 0x10FF and writes outside the window do not use up the one allowed write.
- R9: Writing any value other than 0x66 or 0x55 to port 0xEA locks the zone.
- R10: An I/O read of port 0xE5 returns, one cycle later on `io_rdata`, a byte whose bit 5 is 1 when the zone is locked and 0 when it is open or one-shot is armed. All other bits are 0. An I/O read of any other port returns 0x00.
- R11: Reads from any address in the window return the stored byte in every protection state.
- R12: A memory write and a control write in the same cycle: the memory write is judged against the protection state held before that cycle, and the control value decides the next state, even when the memory write uses up a one-shot.
- R13: I/O writes to any port other than 0xEA leave the protection state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_en | input | 1 | Memory cycle request |
| mem_we | input | 1 | 1 = write, 0 = read for a memory cycle |
| mem_addr | input | 16 | Memory address |
| mem_wdata | input | 8 | Memory write data |
| mem_rdata | output | 8 | Registered memory read data |
| io_en | input | 1 | I/O cycle request |
| io_we | input | 1 | 1 = write, 0 = read for an I/O cycle |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Registered I/O read data |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit data path, the window at 0x1000, 256 bytes with a 64-byte guarded zone, the control port at 0xEA and the status port at 0xE5. With these values the whole memory can be filled and checked, and random addresses reach both the guarded and the free part of the window, plus aliases just outside it. Random control writes, mostly the two special codes, move the protection state often. The random traffic also produces same-cycle control and memory writes, so the priority rule of R12 gets exercised, not only the directed cases.

// File: rtl/scratch_guard_pkg.sv
package scratch_guard_pkg;

  typedef enum logic [1:0] {
    GUARD_LOCKED = 2'd0,
    GUARD_OPEN   = 2'd1,
    GUARD_ONCE   = 2'd2
  } guard_mode_e;

endpackage

// File: rtl/window_decode.sv
module window_decode #(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 16'h1000,
  parameter int                DEPTH_LOG2 = 8,
  parameter int                GUARD_LOG2 = 6
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic                  hit,
  output logic                  in_guard,
  output logic [DEPTH_LOG2-1:0] offset
);

  localparam int TAG_W = ADDR_W - DEPTH_LOG2;
  localparam int SEL_W = DEPTH_LOG2 - GUARD_LOG2;
  localparam logic [TAG_W-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:DEPTH_LOG2];

  logic [TAG_W-1:0] tag;
  logic [SEL_W-1:0] zone_sel;

  always_comb begin
    tag      = addr[ADDR_W-1:DEPTH_LOG2];
    offset   = addr[DEPTH_LOG2-1:0];
    zone_sel = offset[DEPTH_LOG2-1:GUARD_LOG2];
    hit      = (tag == BASE_TAG);
    in_guard = hit && (zone_sel == '0);
  end

  initial begin
    if (GUARD_LOG2 >= DEPTH_LOG2)
      $error("window_decode: guarded zone must be smaller than the RAM");
  end

endmodule

// File: rtl/guard_fsm.sv
module guard_fsm
  import scratch_guard_pkg::*;
#(
  parameter int              IO_W      = 8,
  parameter logic [IO_W-1:0] OPEN_CODE = 8'h66,
  parameter logic [IO_W-1:0] ONCE_CODE = 8'h55
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctrl_wr,
  input  logic [IO_W-1:0] ctrl_data,
  input  logic            guard_wr,
  output guard_mode_e     mode,
  output logic            wr_allow,
  output logic            locked
);

  guard_mode_e mode_q, mode_d;
  logic        consume;

  always_comb begin
    consume = guard_wr && (mode_q == GUARD_ONCE);
    mode_d  = mode_q;
    if (ctrl_wr) begin
      if (ctrl_data == OPEN_CODE)      mode_d = GUARD_OPEN;
      else if (ctrl_data == ONCE_CODE) mode_d = GUARD_ONCE;
      else                             mode_d = GUARD_LOCKED;
    end else if (consume) begin
      mode_d = GUARD_LOCKED;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= GUARD_LOCKED;
    else     mode_q <= mode_d;
  end

  assign mode     = mode_q;
  assign locked   = (mode_q == GUARD_LOCKED);
  assign wr_allow = !locked;

  // R3
  reset_locks_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> locked);

  // R7
  once_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    (guard_wr && mode_q == GUARD_ONCE && !ctrl_wr) |=> locked);

  // R8
  once_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!guard_wr && mode_q == GUARD_ONCE && !ctrl_wr) |=> (mode_q == GUARD_ONCE));

  // R6
  open_code_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ctrl_data == OPEN_CODE) |=> (mode_q == GUARD_OPEN));

  // R9
  other_code_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ctrl_data != OPEN_CODE && ctrl_data != ONCE_CODE) |=> locked);

  // R13
  no_ctrl_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_wr && !guard_wr) |=> $stable(mode_q));

endmodule

// File: rtl/ram_core.sv
module ram_core #(
  parameter int DEPTH_LOG2 = 8,
  parameter int DATA_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic                  wr_en,
  input  logic [DEPTH_LOG2-1:0] addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata
);

  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (wr_en) store[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= store[addr];
  end

  assign rdata = rdata_q;

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_q));

  // R2
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));

endmodule

// File: rtl/status_port.sv
module status_port #(
  parameter int               IOA_W     = 8,
  parameter int               IO_W      = 8,
  parameter logic [IOA_W-1:0] STAT_PORT = 8'hE5,
  parameter int               STAT_BIT  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IOA_W-1:0] addr,
  input  logic             locked,
  output logic [IO_W-1:0]  rdata
);

  logic [IO_W-1:0] stat_word;
  logic [IO_W-1:0] rdata_q;

  always_comb begin
    stat_word           = '0;
    stat_word[STAT_BIT] = locked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      if (addr == STAT_PORT) rdata_q <= stat_word;
      else                   rdata_q <= '0;
    end
  end

  assign rdata = rdata_q;

  // R10
  stat_reflects_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == STAT_PORT) |=> (rdata_q[STAT_BIT] == $past(locked)));

  // R10
  other_port_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != STAT_PORT) |=> (rdata_q == '0));

  // R10
  spare_bits_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(rdata_q) <= 1);

endmodule

// File: rtl/scratch_guard_ram.sv
module scratch_guard_ram
  import scratch_guard_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter int                IOA_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 16'h1000,
  parameter int                DEPTH_LOG2 = 8,
  parameter int                GUARD_LOG2 = 6,
  parameter logic [IOA_W-1:0]  CTRL_PORT  = 8'hEA,
  parameter logic [IOA_W-1:0]  STAT_PORT  = 8'hE5,
  parameter logic [DATA_W-1:0] OPEN_CODE  = 8'h66,
  parameter logic [DATA_W-1:0] ONCE_CODE  = 8'h55,
  parameter int                STAT_BIT   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_en,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] mem_rdata,
  input  logic              io_en,
  input  logic              io_we,
  input  logic [IOA_W-1:0]  io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata
);

  logic                  win_hit;
  logic                  win_guard;
  logic [DEPTH_LOG2-1:0] win_off;
  logic                  wr_hit;
  logic                  rd_hit;
  logic                  guard_wr;
  logic                  ram_we;
  logic                  ctrl_wr;
  logic                  stat_rd;
  logic                  wr_allow;
  logic                  locked;
  guard_mode_e           mode;

  window_decode #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .DEPTH_LOG2(DEPTH_LOG2),
    .GUARD_LOG2(GUARD_LOG2)
  ) u_decode (
    .addr    (mem_addr),
    .hit     (win_hit),
    .in_guard(win_guard),
    .offset  (win_off)
  );

  always_comb begin
    wr_hit   = mem_en && mem_we && win_hit;
    rd_hit   = mem_en && !mem_we && win_hit;
    guard_wr = wr_hit && win_guard;
    ram_we   = wr_hit && (!win_guard || wr_allow);
    ctrl_wr  = io_en && io_we && (io_addr == CTRL_PORT);
    stat_rd  = io_en && !io_we;
  end

  guard_fsm #(
    .IO_W     (DATA_W),
    .OPEN_CODE(OPEN_CODE),
    .ONCE_CODE(ONCE_CODE)
  ) u_guard (
    .clk      (clk),
    .rst      (rst),
    .ctrl_wr  (ctrl_wr),
    .ctrl_data(io_wdata),
    .guard_wr (guard_wr),
    .mode     (mode),
    .wr_allow (wr_allow),
    .locked   (locked)
  );

  ram_core #(
    .DEPTH_LOG2(DEPTH_LOG2),
    .DATA_W    (DATA_W)
  ) u_ram (
    .clk  (clk),
    .rst  (rst),
    .rd_en(rd_hit),
    .wr_en(ram_we),
    .addr (win_off),
    .wdata(mem_wdata),
    .rdata(mem_rdata)
  );

  status_port #(
    .IOA_W    (IOA_W),
    .IO_W     (DATA_W),
    .STAT_PORT(STAT_PORT),
    .STAT_BIT (STAT_BIT)
  ) u_status (
    .clk   (clk),
    .rst   (rst),
    .rd_en (stat_rd),
    .addr  (io_addr),
    .locked(locked),
    .rdata (io_rdata)
  );

  // R4
  locked_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we && win_guard && mode == GUARD_LOCKED) |-> !ram_we);

  // R5
  free_zone_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we && win_hit && !win_guard) |-> ram_we);

  // R1
  outside_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !win_hit) |-> (!ram_we && !rd_hit));

  // R1
  outside_read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we && !win_hit) |=> $stable(mem_rdata));

endmodule

// File: tb/test_scratch_guard_ram.sv
module test_scratch_guard_ram;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_en = 1'b0, mem_we = 1'b0;
  logic [15:0] mem_addr = '0;
  logic [7:0]  mem_wdata = '0;
  logic [7:0]  mem_rdata;
  logic        io_en = 1'b0, io_we = 1'b0;
  logic [7:0]  io_addr = '0, io_wdata = '0;
  logic [7:0]  io_rdata;

  int checks = 0;
  int errors = 0;

  // model: 0 locked, 1 open, 2 one-shot
  int         m_mode;
  logic [7:0] m_mem [256];
  logic [7:0] m_mrd;
  logic [7:0] m_iord;

  always #4 clk = ~clk;

  scratch_guard_ram i_scratch_guard_ram (
    .clk(clk), .rst(rst),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .io_en(io_en), .io_we(io_we), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [15:0] a);
    return a[15:8] == 8'h10;
  endfunction

  function automatic bit in_zone(input logic [15:0] a);
    return in_win(a) && a[7:6] == 2'b00;
  endfunction

  function automatic int decode_ctrl(input logic [7:0] v);
    if (v == 8'h66) return 1;
    if (v == 8'h55) return 2;
    return 0;
  endfunction

  // one bus cycle; model updated from the state before the edge
  task automatic step(input bit me, input bit mw, input logic [15:0] ma,
                      input logic [7:0] md, input bit ie, input bit iw,
                      input logic [7:0] ia, input logic [7:0] id,
                      input string req);
    int  nxt;
    bit  consume;
    @(negedge clk);
    mem_en = me; mem_we = mw; mem_addr = ma; mem_wdata = md;
    io_en = ie; io_we = iw; io_addr = ia; io_wdata = id;
    nxt = m_mode;
    consume = 1'b0;
    if (me && !mw && in_win(ma)) m_mrd = m_mem[ma[7:0]];
    if (ie && !iw) m_iord = (ia == 8'hE5) ? ((m_mode == 0) ? 8'h20 : 8'h00) : 8'h00;
    if (me && mw && in_win(ma)) begin
      if (!in_zone(ma) || m_mode != 0) m_mem[ma[7:0]] = md;
      if (in_zone(ma) && m_mode == 2) consume = 1'b1;
    end
    if (ie && iw && ia == 8'hEA) nxt = decode_ctrl(id);
    else if (consume) nxt = 0;
    m_mode = nxt;
    @(posedge clk);
    #1;
    chk(mem_rdata === m_mrd, {req, " mem_rdata"}, mem_rdata, m_mrd);
    if (ie && !iw) chk(io_rdata === m_iord, {req, " io_rdata"}, io_rdata, m_iord);
    @(negedge clk);
    mem_en = 1'b0; io_en = 1'b0;
  endtask

  task automatic mwr(input logic [15:0] a, input logic [7:0] d, input string req);
    step(1, 1, a, d, 0, 0, 8'h00, 8'h00, req);
  endtask
  task automatic mrd(input logic [15:0] a, input string req);
    step(1, 0, a, 8'h00, 0, 0, 8'h00, 8'h00, req);
  endtask
  task automatic ctl(input logic [7:0] v, input string req);
    step(0, 0, 16'h0000, 8'h00, 1, 1, 8'hEA, v, req);
  endtask
  task automatic stat(input string req);
    step(0, 0, 16'h0000, 8'h00, 1, 0, 8'hE5, 8'h00, req);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_mode = 0; m_mrd = 8'h00; m_iord = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R2 R3 reset state
    chk(mem_rdata === 8'h00, "R2 reset mem_rdata", mem_rdata, 8'h00);
    chk(io_rdata === 8'h00, "R3 reset io_rdata", io_rdata, 8'h00);
    stat("R3 R10 locked after reset");
    // R6 open then fill the RAM
    ctl(8'h66, "R6");
    stat("R6 status open");
    for (int i = 0; i < 256; i++) mwr(16'h1000 + 16'(i), 8'(i) ^ 8'h5A, "R6 fill");
    mrd(16'h1005, "R6 R11 readback");
    mrd(16'h10FF, "R2 last byte");
    // R9 lock with other value
    ctl(8'h12, "R9");
    stat("R9 status locked");
    mwr(16'h1005, 8'hAA, "R4");
    mrd(16'h1005, "R4 R11 unchanged");
    mwr(16'h103F, 8'hAB, "R4");
    mrd(16'h103F, "R4 top of zone");
    mwr(16'h1040, 8'h77, "R5");
    mrd(16'h1040, "R5 readback");
    // R7 R8 one-shot
    ctl(8'h55, "R7");
    stat("R7 R10 armed reads writable");
    mwr(16'h10C0, 8'h11, "R8");
    mwr(16'h2001, 8'h12, "R8 outside");
    stat("R8 still armed");
    mwr(16'h1001, 8'h33, "R7 one write");
    mwr(16'h1002, 8'h44, "R7 second dropped");
    mrd(16'h1001, "R7 first stored");
    mrd(16'h1002, "R7 second unchanged");
    stat("R7 relocked");
    // R1 outside window
    mwr(16'h2005, 8'h99, "R1");
    mwr(16'h0F05, 8'h98, "R1");
    mrd(16'h1005, "R1 no alias");
    mrd(16'h2005, "R1 R2 hold");
    // R12 same-cycle writes
    ctl(8'h55, "R12 arm");
    step(1, 1, 16'h1003, 8'hC3, 1, 1, 8'hEA, 8'h55, "R12 consume vs rearm");
    mwr(16'h1004, 8'hC4, "R12 still one-shot");
    mrd(16'h1003, "R12"); mrd(16'h1004, "R12");
    step(1, 1, 16'h1006, 8'hC6, 1, 1, 8'hEA, 8'h66, "R12 old lock applies");
    mrd(16'h1006, "R12 dropped");
    stat("R12 open now");
    // R13 other ports
    ctl(8'h00, "R13 lock");
    step(0, 0, 16'h0, 8'h0, 1, 1, 8'hE9, 8'h66, "R13 other port write");
    stat("R13 still locked");
    step(0, 0, 16'h0, 8'h0, 1, 0, 8'h33, 8'h0, "R10 other port read");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      logic [7:0]  v;
      int          r;
      r = $urandom_range(0, 99);
      a = ($urandom_range(0, 9) == 0) ? 16'($urandom) : {8'h10, 8'($urandom)};
      if ($urandom_range(0, 1) == 0) a[7:6] = 2'b00;
      v = 8'($urandom);
      if (r < 40)      mwr(a, v, "R4 R5 R7 random write");
      else if (r < 70) mrd(a, "R11 random read");
      else if (r < 85) begin
        r = $urandom_range(0, 2);
        ctl((r == 0) ? 8'h66 : (r == 1) ? 8'h55 : v, "R6 R7 R9 random ctrl");
      end
      else if (r < 93) stat("R10 random status");
      else step(1, $urandom_range(0, 1), a, v, 1, $urandom_range(0, 1),
                ($urandom_range(0, 1) == 0) ? 8'hEA : 8'hE5,
                ($urandom_range(0, 1) == 0) ? 8'h55 : v, "R12 random mix");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
  end

endmodule